// File: doc/BRIEF.md
# Edge-Selectable Dual Event Latch with Active-Low Interrupt Requests

This block watches two asynchronous external signals, a horizontal sync input and a power-sense input. Each goes to a sticky latch. Software picks, per channel, whether a rising or a falling transition sets that channel's latch. Once set, a latch stays set until software clears it.

Each latch drives an active-low interrupt request toward the CPU core. The sync channel feeds request line 0 and the power channel feeds request line 4. A per-channel enable gates each request. A disabled request is held high, while its latch keeps capturing events.

A single write-only control byte at a fixed bus address holds all settings: the edge selection and interrupt enable for each channel, plus a clear strobe for each channel. The clear strobes do not keep their value. A read-only status byte reports the state of the sync latch.

Top module: `edgeIrqLatch`

## Requirements
- R1: While reset is asserted and directly after it, both latches are cleared, `syncIrqN` and `pwrIrqN` are 1, and `statusByte` is 0x00.
- R2: With its edge-select bit at 1 (bit 1 for sync, bit 4 for power), a 0-to-1 transition on the channel input sets that channel's latch.
- R3: With its edge-select bit at 0, a 1-to-0 transition sets the latch. A transition of the other polarity, or a change of the edge-select bit while the input is steady, leaves the latch unchanged.
- R4: A set latch stays set when the input returns to its former level or keeps toggling.
- R5: Writing the control byte with bit 3 (sync) or bit 6 (power) at 1 clears the matching latch. The strobe lasts one cycle, so a later edge sets the latch again until another 1 is written.
- R6: Control writes with both clear bits at 0 leave the latches unchanged. Writes to any other address change nothing.
- R7: With its enable bit at 1 (bit 2 for sync, bit 5 for power), an interrupt output is the inverse of its latch. With the enable bit at 0 the output is held at 1, and the latch still captures edges.
- R8: `statusByte` bit 3 equals the sync latch state. All other status bits read 0.
- R9: When an edge sets a latch in the same cycle that its clear strobe acts, the latch ends up set.
- R10: The two channels are independent. An edge or a clear on one channel never changes the other.
- R11: An input transition first shows on the interrupt output after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Write address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| syncIn | input | 1 | Asynchronous horizontal sync input |
| pwrIn | input | 1 | Asynchronous power-sense input |
| syncIrqN | output | 1 | Active-low interrupt request 0 (sync channel) |
| pwrIrqN | output | 1 | Active-low interrupt request 4 (power channel) |
| statusByte | output | 8 | Status byte; bit 3 is the sync latch |

## Verification
A latch stuck or wrongly set shows on `statusByte` bit 3 or on an enabled request line within three cycles of the transition that should have moved it. A clear strobe that is held or lost shows two cycles after the write: either the latch fails to clear, or it refuses to set on the next edge. Bad edge polarity or bad enable state shows as a request that falls on the wrong transition, or that falls while disabled. Lost-event ordering is tested by aligning an edge exactly with a clear strobe.

// File: rtl/edgeIrqPkg.sv
package edgeIrqPkg;
  localparam int CH_COUNT     = 2;
  localparam int CH_SYNC      = 0;
  localparam int CH_PWR       = 1;
  // control byte field layout: each channel owns three adjacent bits
  localparam int FIELD_BASE   = 1;
  localparam int FIELD_STRIDE = 3;
  localparam int EDGE_OFS     = 0;
  localparam int EN_OFS       = 1;
  localparam int CLR_OFS      = 2;
  localparam int STATUS_SYNC_BIT = 3;

  typedef struct packed {
    logic [CH_COUNT-1:0] riseSel;
    logic [CH_COUNT-1:0] irqEn;
    logic [CH_COUNT-1:0] clrPulse;
  } ctrlStrobes_t;

  function automatic int fieldBit(int ch, int ofs);
    return FIELD_BASE + FIELD_STRIDE * ch + ofs;
  endfunction
endpackage

// File: rtl/edgeIrqCtrl.sv
module edgeIrqCtrl
  import edgeIrqPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output ctrlStrobes_t      strobes
);
  logic wrHit;
  logic [CH_COUNT-1:0] riseReg, enReg, clrReg;
  logic unusedDataBits;

  assign wrHit = busWrEn && (busAddr == CTRL_ADDR);
  assign unusedDataBits = busWrData[0] ^ busWrData[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseReg <= '0;
      enReg   <= '0;
      clrReg  <= '0;
    end else begin
      clrReg <= '0;
      if (wrHit) begin
        for (int ch = 0; ch < CH_COUNT; ch++) begin
          riseReg[ch] <= busWrData[fieldBit(ch, EDGE_OFS)];
          enReg[ch]   <= busWrData[fieldBit(ch, EN_OFS)];
          clrReg[ch]  <= busWrData[fieldBit(ch, CLR_OFS)];
        end
      end
    end
  end

  assign strobes.riseSel  = riseReg;
  assign strobes.irqEn    = enReg;
  assign strobes.clrPulse = clrReg;
endmodule

// File: rtl/edgeIrqDatapath.sv
module edgeIrqDatapath
  import edgeIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] rawIn,
  input  ctrlStrobes_t        strobes,
  output logic [CH_COUNT-1:0] latched,
  output logic [CH_COUNT-1:0] irqN
);
  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : gCh
    logic [SYNC_STAGES-1:0] syncChain;
    logic prevSample, curSample, riseSeen, fallSeen, hit, latchQ;

    assign curSample = syncChain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncChain  <= '0;
        prevSample <= 1'b0;
      end else begin
        syncChain  <= {syncChain[SYNC_STAGES-2:0], rawIn[ch]};
        prevSample <= curSample;
      end
    end

    always_comb begin
      riseSeen = curSample & ~prevSample;
      fallSeen = ~curSample & prevSample;
      hit      = strobes.riseSel[ch] ? riseSeen : fallSeen;
    end

    // a captured edge takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rstN)                       latchQ <= 1'b0;
      else if (hit)                    latchQ <= 1'b1;
      else if (strobes.clrPulse[ch])   latchQ <= 1'b0;
    end

    assign latched[ch] = latchQ;
    assign irqN[ch]    = ~(strobes.irqEn[ch] & latchQ);
  end
endmodule

// File: rtl/edgeIrqLatch.sv
module edgeIrqLatch
  import edgeIrqPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h29,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              syncIn,
  input  logic              pwrIn,
  output logic              syncIrqN,
  output logic              pwrIrqN,
  output logic [DATA_W-1:0] statusByte
);
  ctrlStrobes_t strobes;
  logic [CH_COUNT-1:0] latched, irqN, rawIn;
  logic unusedPwrLatch;

  assign rawIn[CH_SYNC] = syncIn;
  assign rawIn[CH_PWR]  = pwrIn;

  edgeIrqCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strobes(strobes)
  );

  edgeIrqDatapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .strobes(strobes),
    .latched(latched), .irqN(irqN)
  );

  assign syncIrqN = irqN[CH_SYNC];
  assign pwrIrqN  = irqN[CH_PWR];
  assign unusedPwrLatch = latched[CH_PWR];

  always_comb begin
    statusByte = '0;
    statusByte[STATUS_SYNC_BIT] = latched[CH_SYNC];
  end
endmodule

// File: rtl/edgeIrqChecker.sv
module edgeIrqChecker #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h29
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              wrSyncEn,
  input logic              wrSyncClr,
  input logic              wrPwrEn,
  input logic              syncIn,
  input logic              syncIrqN,
  input logic              pwrIrqN,
  input logic              syncLatched
);
  logic ctrlWr, shSyncEn, shPwrEn;
  assign ctrlWr = busWrEn && (busAddr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shSyncEn <= 1'b0;
      shPwrEn  <= 1'b0;
    end else if (ctrlWr) begin
      shSyncEn <= wrSyncEn;
      shPwrEn  <= wrPwrEn;
    end
  end

  assert_sync_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !shSyncEn |-> syncIrqN);
  assert_pwr_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !shPwrEn |-> pwrIrqN);
  assert_status_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    shSyncEn |-> (syncIrqN == !syncLatched));
  assert_set_origin_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncLatched) |-> ($past(syncIn, 3) != $past(syncIn, 4)));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlWr && wrSyncClr, 2) && ($past(syncIn, 3) == $past(syncIn, 4)))
      |-> !syncLatched);
endmodule

bind edgeIrqLatch edgeIrqChecker #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .wrSyncEn(busWrData[2]), .wrSyncClr(busWrData[3]), .wrPwrEn(busWrData[5]),
  .syncIn(syncIn), .syncIrqN(syncIrqN), .pwrIrqN(pwrIrqN),
  .syncLatched(statusByte[3])
);

// File: tb/sim_edgeIrqLatch.sv
module sim_edgeIrqLatch;
  localparam logic [7:0] ADDR = 8'h29;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0;
  logic busWrEn = 1'b0, syncIn = 1'b0, pwrIn = 1'b0;
  logic syncIrqN, pwrIrqN;
  logic [7:0] statusByte;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic  expSync;
    logic  expPwr;
    logic [7:0] expStatus;
    string tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #5 clk = ~clk;

  edgeIrqLatch u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .syncIn(syncIn), .pwrIn(pwrIn),
    .syncIrqN(syncIrqN), .pwrIrqN(pwrIrqN), .statusByte(statusByte)
  );

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        compared++;
        if (syncIrqN !== it.expSync || pwrIrqN !== it.expPwr || statusByte !== it.expStatus) begin
          mismatched++;
          $display("FAIL %s: got sync=%b pwr=%b status=%h, expected sync=%b pwr=%b status=%h",
                   it.tag, syncIrqN, pwrIrqN, statusByte, it.expSync, it.expPwr, it.expStatus);
        end
      end
    end
  end

  task automatic expectNow(logic s, logic p, logic [7:0] st, string tag);
    expItem_t it;
    it.expSync = s; it.expPwr = p; it.expStatus = st; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectNow(1, 1, 8'h00, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    expectNow(1, 1, 8'h00, "R1 after reset");

    // rising mode, both disabled (bits 1,4)
    busWrite(ADDR, 8'h12);
    syncIn = 1'b1; settle();
    expectNow(1, 1, 8'h08, "R7 disabled sync still latches");
    pwrIn = 1'b1; settle();
    expectNow(1, 1, 8'h08, "R7 disabled pwr held high");

    // enable both, rising mode
    busWrite(ADDR, 8'h36);
    expectNow(0, 0, 8'h08, "R7 enabled outputs follow latches R2");

    // clear sync only (bit 3)
    busWrite(ADDR, 8'h3E);
    expectNow(1, 0, 8'h00, "R5 sync clear R10 pwr kept");
    busWrite(ADDR, 8'h76);
    expectNow(1, 1, 8'h00, "R5 pwr clear");

    // opposite edge ignored in rising mode
    syncIn = 1'b0; settle();
    expectNow(1, 1, 8'h00, "R3 falling ignored in rising mode");
    syncIn = 1'b1; settle();
    expectNow(0, 1, 8'h08, "R2 rising sets sync R10");
    syncIn = 1'b0; settle();
    expectNow(0, 1, 8'h08, "R4 sticky after input returns");

    busWrite(ADDR, 8'h36);
    expectNow(0, 1, 8'h08, "R6 write with clear bits 0");
    busWrite(8'h2A, 8'hFF);
    expectNow(0, 1, 8'h08, "R6 foreign address clear ignored");
    busWrite(8'h28, 8'h00);
    expectNow(0, 1, 8'h08, "R6 foreign address disable ignored");

    busWrite(ADDR, 8'h3E);
    expectNow(1, 1, 8'h00, "R5 cleared again");
    syncIn = 1'b1; settle();
    expectNow(0, 1, 8'h08, "R5 strobe not held, new edge sets");

    // falling mode with both clears (bits 2,5 enable; 3,6 clear; edges 0)
    busWrite(ADDR, 8'h6C);
    expectNow(1, 1, 8'h00, "R3 mode change on steady input no set");
    pwrIn = 1'b0; settle();
    expectNow(1, 0, 8'h00, "R3 falling sets pwr R10 sync untouched");
    pwrIn = 1'b1; settle();
    expectNow(1, 0, 8'h00, "R4 pwr sticky across toggle");

    // latency: falling edge on sync
    syncIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expectNow(1, 0, 8'h00, "R11 not visible after two edges");
    expectNow(0, 0, 8'h08, "R11 visible after third edge");

    // set-wins: edge detection aligned with clear strobe
    busWrite(ADDR, 8'h6C);
    expectNow(1, 1, 8'h00, "R5 both cleared in falling mode");
    syncIn = 1'b1; settle();
    expectNow(1, 1, 8'h00, "R3 rising ignored in falling mode");
    syncIn = 1'b0;
    @(negedge clk);
    busAddr = ADDR; busWrData = 8'h6C; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    settle();
    expectNow(0, 1, 8'h08, "R9 set wins over simultaneous clear");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule